// File: doc/BRIEF.md
# Submission/Completion Queue Doorbell Tracker

This block sits on the controller side of a host-memory queueing scheme. The host keeps several circular submission rings, where it places 64-byte commands, and several circular completion rings, where the controller returns 16-byte results. The block stores a base address and a depth for every ring, and a binding from each submission ring to one completion ring. It takes the host's doorbell writes, which carry a new submission tail or a new completion head, and keeps head and tail indices for every ring.

On the fetch side, the block issues one memory read request at a time for the oldest unread entry of the lowest-numbered submission ring that holds work. Ring 0 is the admin ring, so it always wins. A grant advances that ring's head. On the completion side, a completion engine offers a finished command as a submission ring number and a command identifier. The block looks up the bound completion ring and forms the slot address and the ownership phase bit. If that ring is full, it holds the request back until the host frees a slot. The phase bit inverts each time the completion tail wraps, so the host can tell fresh entries from stale ones without reading any register.

Top module: `qpair_doorbell_ctl`

## Requirements
- R1: After reset every index is 0, every completion phase is 1, every ring has depth 1, `sq_busy` is 0, `fet_req`, `wr_req` and `db_err` are low.
- R2: The fetch address is the ring base plus head×64. The completion address is the bound ring's base plus tail×16.
- R3: `sq_busy[i]` is high while submission ring i has head ≠ tail. `fet_req` is high when any bit of `sq_busy` is set, and `fet_qid` names the lowest-numbered busy ring.
- R4: While `fet_req` and `fet_gnt` are both high, the selected ring's head advances by one, wrapping from depth−1 to 0. While the request is not granted, it holds steady.
- R5: A completion goes to the completion ring chosen by `cfg_cqid` when the submission ring was created. Two or more submission rings may share one completion ring.
- R6: `wr_phase` is the bound completion ring's phase. The phase inverts when a granted completion moves that ring's tail from depth−1 to 0.
- R7: A completion ring is full when (tail+1) mod depth equals its head. While the bound ring is full, `wr_req` stays low even with `cpl_valid` high. It rises once a head doorbell frees a slot.
- R8: A doorbell whose value is ≥ the ring depth, or that names a completion ring that does not exist, changes no index. `db_err` is high for the one cycle after such a write.
- R9: `wr_cid` and `wr_sqid` carry the offered identifier and ring number unchanged, in whatever order completions are offered.
- R10: A configuration write (`cfg_cq`=0 for a submission ring, 1 for a completion ring) loads the base and depth−1, clears both indices, and sets the phase of a completion ring back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Create or re-create a ring |
| cfg_cq | input | 1 | 1 = completion ring, 0 = submission ring |
| cfg_qid | input | SQ_W | Ring number |
| cfg_base | input | ADDR_W | Ring base address in host memory |
| cfg_last | input | IDX_W | Ring depth minus one |
| cfg_cqid | input | CQ_W | Completion ring bound to a submission ring |
| db_we | input | 1 | Doorbell write |
| db_cq | input | 1 | 1 = completion head doorbell, 0 = submission tail doorbell |
| db_qid | input | SQ_W | Ring number of the doorbell |
| db_val | input | IDX_W | New index value |
| db_err | output | 1 | Previous doorbell was rejected |
| sq_busy | output | NUM_SQ | Per submission ring: entries waiting |
| fet_req | output | 1 | Fetch read request |
| fet_qid | output | SQ_W | Submission ring being fetched |
| fet_addr | output | ADDR_W | Address of the entry to fetch |
| fet_gnt | input | 1 | Fetch request accepted |
| cpl_valid | input | 1 | Completion offered |
| cpl_sqid | input | SQ_W | Submission ring of the completed command |
| cpl_cid | input | CID_W | Command identifier |
| cpl_ready | output | 1 | Completion accepted this cycle |
| wr_req | output | 1 | Completion write request |
| wr_addr | output | ADDR_W | Completion slot address |
| wr_phase | output | 1 | Phase bit to write into the slot |
| wr_cid | output | CID_W | Command identifier to write |
| wr_sqid | output | SQ_W | Submission ring number to write |
| wr_gnt | input | 1 | Completion write accepted |

## Verification
The hardest state to reach is a completion ring that has wrapped, has its phase inverted, and has then filled up again. This needs the correct mix of granted completions and host head doorbells, and no single pattern of inputs produces it. The bench drives a three-slot completion ring that two submission rings share. It fills the ring, checks the stall, frees one slot, and posts across the wrap. It then refills the ring and checks that the next slot carries phase 0. Submission ring wrap gets the same treatment on a two-entry ring, after the higher-priority rings have been drained.

// File: rtl/qpair_doorbell_ctl.sv
module qpair_doorbell_ctl #(
  parameter int NUM_SQ = 4,
  parameter int NUM_CQ = 2,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 48,
  parameter int CID_W  = 16,
  localparam int SQ_W  = NUM_SQ > 1 ? $clog2(NUM_SQ) : 1,
  localparam int CQ_W  = NUM_CQ > 1 ? $clog2(NUM_CQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_cq,
  input  logic [SQ_W-1:0]   cfg_qid,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  cfg_last,
  input  logic [CQ_W-1:0]   cfg_cqid,
  input  logic              db_we,
  input  logic              db_cq,
  input  logic [SQ_W-1:0]   db_qid,
  input  logic [IDX_W-1:0]  db_val,
  output logic              db_err,
  output logic [NUM_SQ-1:0] sq_busy,
  output logic              fet_req,
  output logic [SQ_W-1:0]   fet_qid,
  output logic [ADDR_W-1:0] fet_addr,
  input  logic              fet_gnt,
  input  logic              cpl_valid,
  input  logic [SQ_W-1:0]   cpl_sqid,
  input  logic [CID_W-1:0]  cpl_cid,
  output logic              cpl_ready,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_phase,
  output logic [CID_W-1:0]  wr_cid,
  output logic [SQ_W-1:0]   wr_sqid,
  input  logic              wr_gnt
);

  logic [ADDR_W-1:0] sq_base [NUM_SQ];
  logic [IDX_W-1:0]  sq_last [NUM_SQ];
  logic [IDX_W-1:0]  sq_head [NUM_SQ];
  logic [IDX_W-1:0]  sq_tail [NUM_SQ];
  logic [CQ_W-1:0]   sq_cq   [NUM_SQ];
  logic [ADDR_W-1:0] cq_base [NUM_CQ];
  logic [IDX_W-1:0]  cq_last [NUM_CQ];
  logic [IDX_W-1:0]  cq_head [NUM_CQ];
  logic [IDX_W-1:0]  cq_tail [NUM_CQ];
  logic [NUM_CQ-1:0] cq_ph;

  logic [NUM_SQ-1:0] sq_dbok;
  logic [NUM_CQ-1:0] cq_dbok;

  always_comb begin
    for (int i = 0; i < NUM_SQ; i++)
      sq_dbok[i] = db_we && !db_cq && db_qid == SQ_W'(i) && db_val <= sq_last[i];
    for (int j = 0; j < NUM_CQ; j++)
      cq_dbok[j] = db_we && db_cq && db_qid == SQ_W'(j) && db_val <= cq_last[j];
  end

  always_ff @(posedge clk)
    if (!rst_n) db_err <= 1'b0;
    else        db_err <= db_we && !(|sq_dbok) && !(|cq_dbok);

  always_comb begin
    fet_req = 1'b0;
    fet_qid = '0;
    for (int i = NUM_SQ - 1; i >= 0; i--) begin
      sq_busy[i] = sq_head[i] != sq_tail[i];
      if (sq_busy[i]) begin
        fet_req = 1'b1;
        fet_qid = SQ_W'(i);
      end
    end
  end

  assign fet_addr = sq_base[fet_qid] + ADDR_W'({sq_head[fet_qid], 6'b0});

  logic [CQ_W-1:0]  pcq;
  logic [IDX_W-1:0] ct, nt;
  logic             cq_full;

  assign pcq       = sq_cq[cpl_sqid];
  assign ct        = cq_tail[pcq];
  assign nt        = (ct == cq_last[pcq]) ? '0 : ct + 1'b1;
  assign cq_full   = nt == cq_head[pcq];
  assign wr_req    = cpl_valid && !cq_full;
  assign wr_addr   = cq_base[pcq] + ADDR_W'({ct, 4'b0});
  assign wr_phase  = cq_ph[pcq];
  assign wr_cid    = cpl_cid;
  assign wr_sqid   = cpl_sqid;
  assign cpl_ready = wr_req && wr_gnt;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SQ; i++) begin
      if (!rst_n) begin
        sq_base[i] <= '0;
        sq_last[i] <= '0;
        sq_head[i] <= '0;
        sq_tail[i] <= '0;
        sq_cq[i]   <= '0;
      end else if (cfg_we && !cfg_cq && cfg_qid == SQ_W'(i)) begin
        sq_base[i] <= cfg_base;
        sq_last[i] <= cfg_last;
        sq_head[i] <= '0;
        sq_tail[i] <= '0;
        sq_cq[i]   <= cfg_cqid;
      end else begin
        if (sq_dbok[i]) sq_tail[i] <= db_val;
        if (fet_req && fet_gnt && fet_qid == SQ_W'(i))
          sq_head[i] <= (sq_head[i] == sq_last[i]) ? '0 : sq_head[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < NUM_CQ; j++) begin
      if (!rst_n) begin
        cq_base[j] <= '0;
        cq_last[j] <= '0;
        cq_head[j] <= '0;
        cq_tail[j] <= '0;
        cq_ph[j]   <= 1'b1;
      end else if (cfg_we && cfg_cq && cfg_qid == SQ_W'(j)) begin
        cq_base[j] <= cfg_base;
        cq_last[j] <= cfg_last;
        cq_head[j] <= '0;
        cq_tail[j] <= '0;
        cq_ph[j]   <= 1'b1;
      end else begin
        if (cq_dbok[j]) cq_head[j] <= db_val;
        if (cpl_ready && pcq == CQ_W'(j)) begin
          cq_tail[j] <= nt;
          if (ct == cq_last[j]) cq_ph[j] <= ~cq_ph[j];
        end
      end
    end
  end

endmodule

// File: rtl/qpair_doorbell_ctl_chk.sv
module qpair_doorbell_ctl_chk #(
  parameter int NUM_SQ = 4,
  parameter int SQ_W   = 2,
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              db_we,
  input logic              db_err,
  input logic [NUM_SQ-1:0] sq_busy,
  input logic              fet_req,
  input logic [SQ_W-1:0]   fet_qid,
  input logic [ADDR_W-1:0] fet_addr,
  input logic              fet_gnt,
  input logic              cpl_valid,
  input logic              wr_req
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!fet_req && !db_err && !wr_req));

  assert_idle_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_busy == '0) |-> !fet_req);

  assert_hold_ungranted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fet_req && !fet_gnt && !cfg_we && !db_we) |=>
      (fet_req && $stable(fet_qid) && $stable(fet_addr)));

  assert_write_needs_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> cpl_valid);

  assert_err_after_doorbell_R8: assert property (@(posedge clk) disable iff (!rst_n)
    db_err |-> $past(db_we));

endmodule

bind qpair_doorbell_ctl qpair_doorbell_ctl_chk #(.NUM_SQ(NUM_SQ), .SQ_W(SQ_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_qpair_doorbell_ctl.sv
`timescale 1ns/100ps
module sim_qpair_doorbell_ctl;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        cfg_we = 0, cfg_cq = 0;
  logic [1:0]  cfg_qid = 0;
  logic [47:0] cfg_base = 0;
  logic [7:0]  cfg_last = 0;
  logic [0:0]  cfg_cqid = 0;
  logic        db_we = 0, db_cq = 0;
  logic [1:0]  db_qid = 0;
  logic [7:0]  db_val = 0;
  logic        db_err;
  logic [3:0]  sq_busy;
  logic        fet_req, fet_gnt = 0;
  logic [1:0]  fet_qid;
  logic [47:0] fet_addr;
  logic        cpl_valid = 0, cpl_ready;
  logic [1:0]  cpl_sqid = 0;
  logic [15:0] cpl_cid = 0;
  logic        wr_req, wr_phase, wr_gnt = 0;
  logic [47:0] wr_addr;
  logic [15:0] wr_cid;
  logic [1:0]  wr_sqid;

  qpair_doorbell_ctl u0 (.*);

  int errors = 0, checks = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(bit cq, int qid, logic [47:0] base, int last, int cqid);
    @(negedge clk);
    cfg_we = 1; cfg_cq = cq; cfg_qid = 2'(qid); cfg_base = base;
    cfg_last = 8'(last); cfg_cqid = 1'(cqid);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic db(bit cq, int qid, int val);
    @(negedge clk);
    db_we = 1; db_cq = cq; db_qid = 2'(qid); db_val = 8'(val);
    @(negedge clk);
    db_we = 0;
  endtask

  task automatic fetch(string req, int qid, logic [47:0] addr);
    @(negedge clk); #1;
    check(req, fet_req, 1);
    check(req, fet_qid, 64'(qid));
    check(req, fet_addr, addr);
    fet_gnt = 1;
    @(negedge clk);
    fet_gnt = 0;
  endtask

  task automatic post(string req, int sqid, int cid, logic [47:0] addr, bit ph);
    @(negedge clk);
    cpl_valid = 1; cpl_sqid = 2'(sqid); cpl_cid = 16'(cid);
    #1;
    check(req, wr_req, 1);
    check(req, wr_addr, addr);
    check(req, wr_phase, ph);
    check("R9", {wr_cid, 2'b0, wr_sqid}, {16'(cid), 2'b0, 2'(sqid)});
    wr_gnt = 1;
    #1 check(req, cpl_ready, 1);
    @(negedge clk);
    wr_gnt = 0; cpl_valid = 0;
  endtask

  // {cq, qid[1:0], val[7:0], exp_err, exp_busy[3:0]}
  localparam logic [15:0] VEC [11] = '{
    {1'b0, 2'd0, 8'd2,   1'b0, 4'b0001},
    {1'b0, 2'd0, 8'd4,   1'b1, 4'b0001},
    {1'b0, 2'd2, 8'd1,   1'b0, 4'b0101},
    {1'b0, 2'd2, 8'd2,   1'b1, 4'b0101},
    {1'b0, 2'd3, 8'd255, 1'b0, 4'b1101},
    {1'b0, 2'd1, 8'd8,   1'b1, 4'b1101},
    {1'b0, 2'd3, 8'd0,   1'b0, 4'b0101},
    {1'b1, 2'd0, 8'd3,   1'b1, 4'b0101},
    {1'b1, 2'd1, 8'd0,   1'b0, 4'b0101},
    {1'b1, 2'd2, 8'd0,   1'b1, 4'b0101},
    {1'b0, 2'd1, 8'd7,   1'b0, 4'b0111}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cpl_valid = 1; cpl_sqid = 0;
    @(negedge clk); #1;
    check("R1 busy", sq_busy, 0);
    check("R1 fet_req", fet_req, 0);
    check("R1 db_err", db_err, 0);
    check("R1 wr_req on depth-1 ring", wr_req, 0);
    cpl_valid = 0;

    cfg(0, 0, 48'h1000, 3, 0);
    cfg(0, 1, 48'h2000, 7, 1);
    cfg(0, 2, 48'h3000, 1, 0);
    cfg(0, 3, 48'h4000, 255, 1);
    cfg(1, 0, 48'h8000, 2, 0);
    cfg(1, 1, 48'h9000, 3, 0);

    foreach (VEC[k]) begin
      db(VEC[k][15], int'(VEC[k][14:13]), int'(VEC[k][12:5]));
      check("R8 err flag", db_err, VEC[k][4]);
      check("R3 busy", sq_busy, VEC[k][3:0]);
    end

    fetch("R2 sq0", 0, 48'h1000);
    fetch("R4 sq0 step", 0, 48'h1040);
    fetch("R3 next ring", 1, 48'h2000);
    db(0, 0, 3);
    fetch("R3 admin priority", 0, 48'h1080);
    for (int k = 1; k < 7; k++) fetch("R4 sq1 drain", 1, 48'h2000 + 48'(k * 64));
    fetch("R2 sq2", 2, 48'h3000);
    @(negedge clk); #1;
    check("R3 all empty", {sq_busy, 3'b0, fet_req}, 0);
    db(0, 2, 0);
    check("R8 valid doorbell", db_err, 0);
    fetch("R4 wrap source", 2, 48'h3040);
    @(negedge clk); #1;
    check("R4 wrapped head empty", sq_busy, 0);

    post("R5 sq2->cq0", 2, 16'hA1, 48'h8000, 1);
    post("R5 sq0->cq0", 0, 16'hB2, 48'h8010, 1);
    @(negedge clk);
    cpl_valid = 1; cpl_sqid = 0; cpl_cid = 16'hC3;
    #1 check("R7 full stall", wr_req, 0);
    @(negedge clk); #1 check("R7 still full", wr_req, 0);
    cpl_valid = 0;
    db(1, 0, 1);
    post("R7 resume", 0, 16'hC3, 48'h8020, 1);
    @(negedge clk);
    cpl_valid = 1; cpl_sqid = 2; cpl_cid = 16'hD4;
    #1 check("R7 full after wrap", wr_req, 0);
    cpl_valid = 0;
    db(1, 0, 2);
    post("R6 inverted phase", 2, 16'hD4, 48'h8000, 0);

    post("R5 sq3->cq1", 3, 16'h1234, 48'h9000, 1);
    post("R5 sq1->cq1", 1, 16'h0042, 48'h9010, 1);

    cfg(1, 0, 48'h8000, 2, 0);
    post("R10 cq recreate", 0, 16'h55, 48'h8000, 1);
    db(0, 0, 1);
    check("R3 sq0 busy", sq_busy[0], 1);
    cfg(0, 0, 48'h1000, 3, 0);
    @(negedge clk); #1;
    check("R10 sq recreate clears", sq_busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule